// File: doc/BRIEF.md
# Oscillator Frequency-Lock Trim Controller

This block holds a digitally trimmed fast oscillator close to a wanted frequency. It runs on the fast clock and watches a slow reference clock, which is a 32768 Hz source divided by 8. A free-running counter is sampled at every rising reference edge. The difference between two successive samples is the number of fast-clock ticks in one reference period. This count is compared with a target of 488 ticks, which corresponds to about 2 MHz.

After each measurement the controller moves the oscillator trim code by exactly one step. It steps up when the oscillator is too slow and down when it is too fast. When the count equals the target, the code is left alone. The trim code has two parts: an 8-bit fine code and a 3-bit coarse range. The fine code carries into the range on overflow and borrows from it on underflow. The range saturates at both ends. At a saturated end the fine code still wraps around.

The reference is brought into the fast domain through a synchronizer before its rising edges are detected. The counter difference is taken modulo its width, so a counter wrap between two samples does not spoil the count.

Top module: `osc_trim_lock`

## Requirements
- R1: While reset is asserted (and after it is released), fine_code is mid-scale (1 << (FINE_W-1), 128 by default) and range_sel is mid-scale (1 << (RANGE_W-1), 4 by default).
- R2: The first rising edge of ref_clk after reset only records a counter sample. fine_code and range_sel do not change.
- R3: When the measured count is below TARGET, fine_code increases by one.
- R4: When the measured count is above TARGET, fine_code decreases by one.
- R5: When the measured count equals TARGET, fine_code and range_sel stay unchanged.
- R6: An increment from fine_code 255 gives fine_code 0 and raises range_sel by one when range_sel is below 7. A decrement from fine_code 0 gives fine_code 255 and lowers range_sel by one when range_sel is above 0.
- R7: With range_sel at 7, an increment from fine_code 255 wraps fine_code to 0 and range_sel stays at 7. With range_sel at 0, a decrement from fine_code 0 wraps fine_code to 255 and range_sel stays at 0.
- R8: The measured count is the number of fast-clock cycles between two consecutive ref_clk rising edges, taken modulo 2^CNT_W. It stays correct when the free-running counter wraps between the two samples.
- R9: Each ref_clk rising edge causes at most one adjustment, however long ref_clk stays high. Between edges, fine_code and range_sel hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Clock from the oscillator being trimmed |
| rst_n | input | 1 | Active-low reset, synchronous to clk_fast |
| ref_clk | input | 1 | Slow reference clock, asynchronous to clk_fast |
| fine_code | output | FINE_W | Fine trim code (tap plus modulation) |
| range_sel | output | RANGE_W | Coarse range select |

## Verification
Several behaviours are checked by assertions on every cycle:
- the single-cycle width of the edge strobe;
- the silence of the first capture after reset;
- the hold of both codes between measurements and on an exact match;
- the one-step move for a slow or fast count;
- the saturated wrap at the top range.

Only the bench scenarios can show the rest:
- that the count really equals the spacing of reference edges, including across counter wraps;
- the carry and borrow walks through every range;
- the bottom saturation;
- that a behavioural oscillator whose period depends on the code is pulled to, and held at, the code that matches the target.

// File: rtl/trim_pkg.sv
package trim_pkg;

    // Direction chosen by the comparator for one reference period
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

endpackage

// File: rtl/trim_ref_sync.sv
module trim_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic rise_o
);
    localparam int SW = (STAGES < 2) ? 2 : STAGES;

    typedef struct packed {
        logic [SW-1:0] sync;
        logic          prev;
        logic          rise;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SW-2:0], ref_i};
        st_d.prev = st_q.sync[SW-1];
        st_d.rise = st_q.sync[SW-1] & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.rise;

    // R9
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rise |=> !st_q.rise)
        else $error("edge strobe wider than one cycle");

endmodule

// File: rtl/trim_period_meter.sv
module trim_period_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    output logic             valid_o,
    output logic [CNT_W-1:0] meas_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
        logic [CNT_W-1:0] meas;
        logic             armed;
        logic             valid;
    } meter_st_t;

    meter_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.cnt   = st_q.cnt + 1'b1;
        st_d.valid = 1'b0;
        if (rise_i) begin
            st_d.cap   = st_q.cnt;
            st_d.meas  = st_q.cnt - st_q.cap;   // modular difference (R8)
            st_d.armed = 1'b1;
            st_d.valid = st_q.armed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign meas_o  = st_q.meas;

    // R2
    first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !st_q.armed) |=> !st_q.valid)
        else $error("first capture produced a measurement");

endmodule

// File: rtl/trim_step_ctrl.sv
module trim_step_ctrl
    import trim_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int FINE_W  = 8,
    parameter int RANGE_W = 3,
    parameter int TARGET  = 488
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [CNT_W-1:0]   meas_i,
    output logic [FINE_W-1:0]  fine_o,
    output logic [RANGE_W-1:0] range_o
);
    localparam logic [CNT_W-1:0]   TARGET_CNT = CNT_W'(TARGET);
    localparam logic [FINE_W-1:0]  FINE_MAX   = {FINE_W{1'b1}};
    localparam logic [FINE_W-1:0]  FINE_MID   = FINE_W'(1) << (FINE_W - 1);
    localparam logic [RANGE_W-1:0] RANGE_MAX  = {RANGE_W{1'b1}};
    localparam logic [RANGE_W-1:0] RANGE_MID  = RANGE_W'(1) << (RANGE_W - 1);

    typedef struct packed {
        logic [FINE_W-1:0]  fine;
        logic [RANGE_W-1:0] range;
    } code_st_t;

    code_st_t st_d, st_q;
    step_e    step;

    always_comb begin
        step = STEP_HOLD;
        if (valid_i) begin
            if (meas_i < TARGET_CNT) begin
                step = STEP_UP;
            end else if (meas_i > TARGET_CNT) begin
                step = STEP_DOWN;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        case (step)
            STEP_UP: begin
                st_d.fine = st_q.fine + 1'b1;
                if (st_q.fine == FINE_MAX && st_q.range != RANGE_MAX) begin
                    st_d.range = st_q.range + 1'b1;
                end
            end
            STEP_DOWN: begin
                st_d.fine = st_q.fine - 1'b1;
                if (st_q.fine == '0 && st_q.range != '0) begin
                    st_d.range = st_q.range - 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.fine  <= FINE_MID;
            st_q.range <= RANGE_MID;
        end else begin
            st_q <= st_d;
        end
    end

    assign fine_o  = st_q.fine;
    assign range_o = st_q.range;

    // R9
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(st_q))
        else $error("trim code moved without a measurement");

    // R5
    equal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && meas_i == TARGET_CNT) |=> $stable(st_q))
        else $error("trim code moved on an exact match");

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && meas_i < TARGET_CNT) |=> (st_q.fine == $past(st_q.fine) + 1'b1))
        else $error("fine code did not rise on a slow count");

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && meas_i > TARGET_CNT) |=> (st_q.fine == $past(st_q.fine) - 1'b1))
        else $error("fine code did not fall on a fast count");

    // R7
    top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && meas_i < TARGET_CNT && st_q.range == RANGE_MAX && st_q.fine == FINE_MAX)
        |=> (st_q.range == RANGE_MAX && st_q.fine == '0))
        else $error("range left its top limit");

endmodule

// File: rtl/osc_trim_lock.sv
module osc_trim_lock #(
    parameter int CNT_W       = 16,
    parameter int FINE_W      = 8,
    parameter int RANGE_W     = 3,
    parameter int TARGET      = 488,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_fast,
    input  logic               rst_n,
    input  logic               ref_clk,
    output logic [FINE_W-1:0]  fine_code,
    output logic [RANGE_W-1:0] range_sel
);
    logic             ref_rise;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_cnt;

    trim_ref_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk_fast),
        .rst_n  (rst_n),
        .ref_i  (ref_clk),
        .rise_o (ref_rise)
    );

    trim_period_meter #(
        .CNT_W (CNT_W)
    ) u_meter (
        .clk     (clk_fast),
        .rst_n   (rst_n),
        .rise_i  (ref_rise),
        .valid_o (meas_valid),
        .meas_o  (meas_cnt)
    );

    trim_step_ctrl #(
        .CNT_W   (CNT_W),
        .FINE_W  (FINE_W),
        .RANGE_W (RANGE_W),
        .TARGET  (TARGET)
    ) u_step (
        .clk     (clk_fast),
        .rst_n   (rst_n),
        .valid_i (meas_valid),
        .meas_i  (meas_cnt),
        .fine_o  (fine_code),
        .range_o (range_sel)
    );

endmodule

// File: tb/osc_trim_lock_tb.sv
module osc_trim_lock_tb;
    localparam int TB_CNT_W = 8;
    localparam int TB_TGT   = 24;
    localparam int SETTLE   = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_clk = 1'b0;
    logic [7:0] fine;
    logic [2:0] rng;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_fine = 128;
    int exp_rng  = 4;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    osc_trim_lock #(
        .CNT_W   (TB_CNT_W),
        .FINE_W  (8),
        .RANGE_W (3),
        .TARGET  (TB_TGT)
    ) u_dut (
        .clk_fast  (clk),
        .rst_n     (rst_n),
        .ref_clk   (ref_clk),
        .fine_code (fine),
        .range_sel (rng)
    );

    task automatic check_codes(string req);
        n_checks++;
        if (int'(fine) != exp_fine || int'(rng) != exp_rng) begin
            n_fail++;
            $display("FAIL %s: fine=%0d range=%0d expected fine=%0d range=%0d",
                     req, fine, rng, exp_fine, exp_rng);
        end
    endtask

    // Expected-value model taken from the stepping requirements
    task automatic model_step(int p);
        if (p < TB_TGT) begin
            if (exp_fine == 255) begin
                exp_fine = 0;
                if (exp_rng < 7) exp_rng++;
            end else exp_fine++;
        end else if (p > TB_TGT) begin
            if (exp_fine == 0) begin
                exp_fine = 255;
                if (exp_rng > 0) exp_rng--;
            end else exp_fine--;
        end
    endtask

    // Assumes a rising edge happened SETTLE cycles ago; places the next one p cycles after it
    task automatic run_period(int p, string req);
        repeat (p / 2 - SETTLE) @(negedge clk);
        ref_clk = 1'b0;
        repeat (p - p / 2) @(negedge clk);
        check_codes("R9");            // no change between edges
        ref_clk = 1'b1;
        model_step(p);
        repeat (SETTLE) @(negedge clk);
        check_codes(req);
    endtask

    task automatic do_reset();
        ref_clk = 1'b0;
        rst_n   = 1'b0;
        repeat (4) @(negedge clk);
        exp_fine = 128;
        exp_rng  = 4;
        check_codes("R1");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_codes("R1");
    endtask

    task automatic t_first_edge();
        ref_clk = 1'b1;
        repeat (SETTLE) @(negedge clk);
        check_codes("R2");
    endtask

    task automatic t_basic_steps();
        run_period(12, "R3");
        run_period(40, "R4");
        run_period(24, "R5");
        run_period(24, "R5");
        run_period(60, "R4");
        run_period(20, "R3");
    endtask

    task automatic t_long_period();
        // periods close to the counter span force a wrap between samples (R8)
        run_period(200, "R8");
        run_period(250, "R8");
        run_period(23, "R8");
    endtask

    task automatic t_carry_up();
        while (!(exp_rng == 7 && exp_fine == 255)) begin
            if (exp_fine == 255) run_period(12, "R6");
            else run_period(12, "R3");
        end
        run_period(12, "R7");
        run_period(12, "R3");
    endtask

    task automatic t_borrow_down();
        while (!(exp_rng == 0 && exp_fine == 0)) begin
            if (exp_fine == 0) run_period(28, "R6");
            else run_period(28, "R4");
        end
        run_period(28, "R7");
    endtask

    // Behavioural oscillator: period count grows with the trim code
    task automatic t_closed_loop();
        for (int i = 0; i < 120; i++) begin
            run_period(16 + exp_fine / 32 + exp_rng * 2, "R5");
        end
        n_checks++;
        if (int'(fine) != 31 || int'(rng) != 4) begin
            n_fail++;
            $display("FAIL R5 lock: fine=%0d range=%0d expected fine=31 range=4", fine, rng);
        end
    endtask

    initial begin
        do_reset();
        t_first_edge();
        t_basic_steps();
        t_long_period();
        t_carry_up();
        t_borrow_down();
        do_reset();
        t_first_edge();
        t_closed_loop();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R9: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule